// File: doc/BRIEF.md
# Nibble-Wide DRAM Access Sequencer

This block runs the access cycle for a dynamic RAM that is four bits wide and addressed through an eight-bit multiplexed bus. Each memory period lasts eight clock cycles, counted by a one-hot phase ring. A period issues one row strobe and two column strobes. Together they fetch one byte as two nibbles: the high nibble comes from column 2n and the low nibble from column 2n+1 of the same row.

The owner of a period is decided at its start. When the video request is high, the period fetches display data from an internal video pointer. The completed byte then appears with a one-cycle valid pulse, and the pointer steps forward by a fixed stride. The stride wraps back by the screen size whenever it reaches the screen limit. When the request is low, the same phase slots serve the CPU address instead. For a CPU read, the fetched byte is assembled into the CPU read-data register. A load input replaces the video pointer at any clock edge.

Top module: `nibble_dram_seq`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o` and `cas_n_o` are 1, `video_valid_o` is 0, and `ram_addr_o`, `video_byte_o` and `cpu_rdata_o` are 0. The phase ring starts at phase 0.
- R2: Phases 0 to 7 repeat every eight cycles. The row strobe falls at the phase-1 edge and rises at the phase-7 edge. The column strobe falls at the phase-2 and phase-5 edges, and rises at the phase-4 and phase-6 edges.
- R3: At the phase-0 edge, `ram_addr_o` takes bits 14..7 of the period address, which is the address shifted right by 7 and truncated to eight bits.
- R4: At the phase-1 edge, `ram_addr_o` becomes {bits 6..0, 0}. At the phase-4 edge it becomes {bits 6..0, 1}. It is held unchanged across each falling edge of the column strobe.
- R5: In a video period, the nibble read at the phase-3 edge becomes `video_byte_o[7:4]`, with the low bits cleared. The nibble read at the phase-6 edge is ORed into `video_byte_o[3:0]`. `video_valid_o` is high for exactly the one cycle after the phase-6 edge.
- R6: `video_req_i`, `cpu_addr_i` and `cpu_rd_i` are sampled at the phase-0 edge. If the request is low, the CPU address drives the row and column addresses of that period.
- R7: In a CPU period with `cpu_rd_i`=1, `cpu_rdata_o` becomes {nibble,0000} at the phase-3 edge, and its low nibble is ORed in at the phase-6 edge. Otherwise `cpu_rdata_o` is unchanged.
- R8: At the phase-6 edge of a video period, the pointer becomes the period address plus STRIDE (default 8). CPU periods leave the pointer unchanged.
- R9: If the advanced pointer is greater than or equal to LIMIT (default 0x8000), SIZE (default 0x5000) is subtracted from it. After reset the pointer is LIMIT-SIZE.
- R10: `video_load_i`=1 at an edge loads `video_addr_i` into the pointer. A load takes priority over an advance at the same edge.
- R11: The column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, eight cycles per memory period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| video_req_i | input | 1 | Gives the next period to video when high |
| video_load_i | input | 1 | Loads the video pointer |
| video_addr_i | input | 16 | Value loaded into the video pointer |
| cpu_addr_i | input | 16 | CPU address |
| cpu_rd_i | input | 1 | CPU read (1) or write (0) |
| ram_data_i | input | 4 | Nibble from the RAM |
| ram_addr_o | output | 8 | Multiplexed row and column address |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| video_byte_o | output | 8 | Assembled video byte |
| video_valid_o | output | 1 | One-cycle pulse when the video byte is complete |
| cpu_rdata_o | output | 8 | Assembled CPU read byte |

## Verification
A behavioural RAM in the bench returns a nibble that depends on both the latched row and the latched column. A swapped nibble order, a wrong column parity or a wrong row slice therefore shows up as a wrong byte. Periods alternate among video, CPU read and CPU write. This separates owner selection from read-data gating, and shows that CPU periods do not advance the pointer. Directed pointer loads cover three cases: plain stride steps, the wrap when the pointer reaches the limit, and a load arriving at the same edge as an advance.

// File: rtl/nds_pkg.sv
package nds_pkg;
  localparam int unsigned NPH = 8;
  localparam int unsigned PH_ROW  = 0;
  localparam int unsigned PH_RAS  = 1;
  localparam int unsigned PH_CAS0 = 2;
  localparam int unsigned PH_HI   = 3;
  localparam int unsigned PH_COL1 = 4;
  localparam int unsigned PH_CAS1 = 5;
  localparam int unsigned PH_LO   = 6;
  localparam int unsigned PH_IDLE = 7;
endpackage

// File: rtl/nds_phase_ring.sv
module nds_phase_ring #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [N-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= N'(1);
    else         phase_o <= {phase_o[N-2:0], phase_o[N-1]};
  end
endmodule

// File: rtl/nds_addr_split.sv
module nds_addr_split #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RA_W   = 8
) (
  input  logic [ADDR_W-1:0] row_src_i,
  input  logic [ADDR_W-1:0] col_src_i,
  output logic [RA_W-1:0]   row_o,
  output logic [RA_W-1:0]   col_even_o,
  output logic [RA_W-1:0]   col_odd_o
);
  localparam int unsigned COL_W = RA_W - 1;

  assign row_o      = row_src_i[COL_W+RA_W-1:COL_W];
  assign col_even_o = {col_src_i[COL_W-1:0], 1'b0};
  assign col_odd_o  = {col_src_i[COL_W-1:0], 1'b1};
endmodule

// File: rtl/nds_nib_assembler.sv
module nds_nib_assembler #(
  parameter int unsigned NIB_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hi_en_i,
  input  logic               lo_en_i,
  input  logic [NIB_W-1:0]   nib_i,
  output logic [2*NIB_W-1:0] byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      byte_o <= '0;
    else if (hi_en_i) byte_o <= {nib_i, {NIB_W{1'b0}}};
    else if (lo_en_i) byte_o <= byte_o | {{NIB_W{1'b0}}, nib_i};
  end
endmodule

// File: rtl/nds_video_ptr.sv
module nds_video_ptr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned STRIDE = 8,
  parameter int unsigned LIMIT  = 32'h8000,
  parameter int unsigned SIZE   = 32'h5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W:0] STRIDE_C = (ADDR_W+1)'(STRIDE);
  localparam logic [ADDR_W:0] LIMIT_C  = (ADDR_W+1)'(LIMIT);
  localparam logic [ADDR_W:0] SIZE_C   = (ADDR_W+1)'(SIZE);
  localparam logic [ADDR_W:0] START_C  = LIMIT_C - SIZE_C;

  logic [ADDR_W:0] sum;
  logic [ADDR_W:0] wrapped;

  always_comb begin
    sum     = {1'b0, base_i} + STRIDE_C;
    wrapped = (sum >= LIMIT_C) ? (sum - SIZE_C) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= START_C[ADDR_W-1:0];
    else if (load_i) ptr_o <= load_addr_i;
    else if (adv_i)  ptr_o <= wrapped[ADDR_W-1:0];
  end
endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RA_W   = 8,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned STRIDE = 8,
  parameter int unsigned LIMIT  = 32'h8000,
  parameter int unsigned SIZE   = 32'h5000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               video_req_i,
  input  logic               video_load_i,
  input  logic [ADDR_W-1:0]  video_addr_i,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic               cpu_rd_i,
  input  logic [NIB_W-1:0]   ram_data_i,
  output logic [RA_W-1:0]    ram_addr_o,
  output logic               ras_n_o,
  output logic               cas_n_o,
  output logic [2*NIB_W-1:0] video_byte_o,
  output logic               video_valid_o,
  output logic [2*NIB_W-1:0] cpu_rdata_o
);
  import nds_pkg::*;

  logic [NPH-1:0]    phase;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] per_addr_q;
  logic [ADDR_W-1:0] live_addr;
  logic              own_vid_q;
  logic              cpu_rd_q;
  logic [RA_W-1:0]   row, col_even, col_odd;

  nds_phase_ring #(.N(NPH)) i_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_o(phase)
  );

  // owner decided at the phase-0 edge; the period address is then frozen
  assign live_addr = video_req_i ? ptr : cpu_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vid_q  <= 1'b0;
      cpu_rd_q   <= 1'b0;
      per_addr_q <= '0;
    end else if (phase[PH_ROW]) begin
      own_vid_q  <= video_req_i;
      cpu_rd_q   <= cpu_rd_i;
      per_addr_q <= live_addr;
    end
  end

  nds_addr_split #(.ADDR_W(ADDR_W), .RA_W(RA_W)) i_split (
    .row_src_i (live_addr),
    .col_src_i (per_addr_q),
    .row_o     (row),
    .col_even_o(col_even),
    .col_odd_o (col_odd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_addr_o <= '0;
      ras_n_o    <= 1'b1;
      cas_n_o    <= 1'b1;
    end else begin
      if (phase[PH_ROW])  ram_addr_o <= row;
      if (phase[PH_RAS])  begin ras_n_o <= 1'b0; ram_addr_o <= col_even; end
      if (phase[PH_CAS0]) cas_n_o <= 1'b0;
      if (phase[PH_COL1]) begin cas_n_o <= 1'b1; ram_addr_o <= col_odd; end
      if (phase[PH_CAS1]) cas_n_o <= 1'b0;
      if (phase[PH_LO])   cas_n_o <= 1'b1;
      if (phase[PH_IDLE]) ras_n_o <= 1'b1;
    end
  end

  // video and cpu byte builders share one structure
  logic [1:0] hi_en, lo_en;
  logic [1:0][2*NIB_W-1:0] bytes;
  assign hi_en[0] = phase[PH_HI] & own_vid_q;
  assign lo_en[0] = phase[PH_LO] & own_vid_q;
  assign hi_en[1] = phase[PH_HI] & ~own_vid_q & cpu_rd_q;
  assign lo_en[1] = phase[PH_LO] & ~own_vid_q & cpu_rd_q;

  for (genvar g = 0; g < 2; g++) begin : g_asm
    nds_nib_assembler #(.NIB_W(NIB_W)) i_asm (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .hi_en_i(hi_en[g]), .lo_en_i(lo_en[g]),
      .nib_i(ram_data_i), .byte_o(bytes[g])
    );
  end
  assign video_byte_o = bytes[0];
  assign cpu_rdata_o  = bytes[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) video_valid_o <= 1'b0;
    else         video_valid_o <= lo_en[0];
  end

  nds_video_ptr #(
    .ADDR_W(ADDR_W), .STRIDE(STRIDE), .LIMIT(LIMIT), .SIZE(SIZE)
  ) i_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(video_load_i), .load_addr_i(video_addr_i),
    .adv_i(lo_en[0]), .base_i(per_addr_q),
    .ptr_o(ptr)
  );
endmodule

// File: rtl/nds_checker.sv
module nds_checker #(
  parameter int unsigned RA_W = 8,
  parameter int unsigned NPH  = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ras_n_i,
  input logic            cas_n_i,
  input logic            valid_i,
  input logic [RA_W-1:0] ram_addr_i,
  input logic [NPH-1:0]  phase_i
);
  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_i |-> !ras_n_i); // R11
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i); // R5
  AST_COL_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_i) |-> $stable(ram_addr_i)); // R4
  AST_COL_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_i) |-> (ram_addr_i[0] == phase_i[6])); // R4
  AST_PHASE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_i) == 1); // R2
  AST_RAS_HELD_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i[2] || phase_i[5]) |-> !ras_n_i); // R2
  AST_RAS_IDLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_i) |=> ras_n_i); // R2
endmodule

bind nibble_dram_seq nds_checker #(.RA_W(RA_W), .NPH(nds_pkg::NPH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_i(ras_n_o), .cas_n_i(cas_n_o),
  .valid_i(video_valid_o), .ram_addr_i(ram_addr_o), .phase_i(phase)
);

// File: tb/test_nibble_dram_seq.sv
module test_nibble_dram_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        video_req_i = 1'b0, video_load_i = 1'b0, cpu_rd_i = 1'b0;
  logic [15:0] video_addr_i = '0, cpu_addr_i = '0;
  logic [3:0]  ram_data_i = '0;
  logic [7:0]  ram_addr_o, video_byte_o, cpu_rdata_o;
  logic        ras_n_o, cas_n_o, video_valid_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  nibble_dram_seq i_nibble_dram_seq (.*);

  function automatic int nib_of(int r, int c);
    return (r * 3 + c * 5 + (c >> 3)) & 15;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int mph, m_vid, m_rd, m_addr, m_row, m_raddr, m_ras, m_cas, m_vb, m_valid, m_crd, m_ptr;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mph = 0; m_vid = 0; m_rd = 0; m_addr = 0; m_row = 0; m_raddr = 0;
      m_ras = 1; m_cas = 1; m_vb = 0; m_valid = 0; m_crd = 0; m_ptr = 32'h3000;
    end else begin
      int nptr, nb;
      nptr = m_ptr; m_valid = 0;
      case (mph)
        0: begin
          m_vid = video_req_i; m_rd = cpu_rd_i;
          m_addr = m_vid ? m_ptr : cpu_addr_i;
          m_row = (m_addr >> 7) & 255; m_raddr = m_row;
        end
        1: begin m_ras = 0; m_raddr = (m_addr & 127) << 1; end
        2: m_cas = 0;
        3: begin
          nb = nib_of(m_row, (m_addr & 127) << 1);
          if (m_vid) m_vb = nb << 4; else if (m_rd) m_crd = nb << 4;
        end
        4: begin m_cas = 1; m_raddr = ((m_addr & 127) << 1) | 1; end
        5: m_cas = 0;
        6: begin
          m_cas = 1;
          nb = nib_of(m_row, ((m_addr & 127) << 1) | 1);
          if (m_vid) begin
            m_vb = m_vb | nb; m_valid = 1;
            nptr = m_addr + 8;
            if (nptr >= 32'h8000) nptr -= 32'h5000;
          end else if (m_rd) m_crd = m_crd | nb;
        end
        default: m_ras = 1;
      endcase
      if (video_load_i) nptr = video_addr_i;
      m_ptr = nptr;
      mph = (mph + 1) % 8;
    end
  end

  // behavioural RAM plus per-cycle comparison
  int a_prev = 0, row_l = 0, col_l = 0, ras_prev = 1, cas_prev = 1;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (!ras_n_o && ras_prev) row_l = a_prev;
      if (!cas_n_o && cas_prev) col_l = ram_addr_o;
      ram_data_i <= cas_n_o ? 4'h0 : 4'(nib_of(row_l, col_l));
      ras_prev = ras_n_o; cas_prev = cas_n_o; a_prev = ram_addr_o;
      chk((mph == 1) ? "R3 row addr" : "R4 col addr", ram_addr_o, m_raddr);
      chk("R2 ras_n", ras_n_o, m_ras);
      chk("R2 cas_n", cas_n_o, m_cas);
      chk("R5 video_valid", video_valid_o, m_valid);
      chk("R5 video_byte", video_byte_o, m_vb);
      chk("R7 cpu_rdata", cpu_rdata_o, m_crd);
      chk("R11 cas under ras", int'(!cas_n_o && ras_n_o), 0);
    end
  end

  task automatic period(bit vid, int addr, bit rd, int ld_at, int ld_addr,
                        int exp_row, int exp_col, string tag);
    while (mph != 0) @(negedge clk_i);
    video_req_i = vid; cpu_addr_i = 16'(addr); cpu_rd_i = rd;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk_i);
      video_load_i = (k == ld_at);
      video_addr_i = 16'(ld_addr);
      if (k == 1 && exp_row >= 0) chk({tag, " row"}, ram_addr_o, exp_row);
      if (k == 2 && exp_col >= 0) chk({tag, " col"}, ram_addr_o, exp_col);
    end
    video_load_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 ras_n", ras_n_o, 1);
    chk("R1 cas_n", cas_n_o, 1);
    chk("R1 valid", video_valid_o, 0);
    chk("R1 addr/bytes", {ram_addr_o, video_byte_o, cpu_rdata_o}, 0);
    rst_ni = 1'b1;
    period(0, 16'hABCD, 1, 0, 0, 8'h57, 8'h9A, "R6 cpu read");
    period(1, 0, 0, 0, 0, 8'h60, 8'h00, "R9 start ptr");
    period(0, 16'h0100, 0, 3, 16'h1234, 8'h02, 8'h00, "R7 cpu write");
    period(1, 0, 0, 0, 0, 8'h24, 8'h68, "R10 load");
    period(1, 0, 0, 0, 0, 8'h24, 8'h78, "R8 stride");
    period(0, 16'h0F0F, 1, 0, 0, 8'h1E, 8'h1E, "R6 cpu read2");
    period(1, 0, 0, 0, 0, 8'h24, 8'h88, "R8 cpu no advance");
    period(0, 0, 0, 2, 16'h7FF8, -1, -1, "load");
    period(1, 0, 0, 0, 0, 8'hFF, 8'hF0, "R9 pre-wrap");
    period(1, 0, 0, 6, 16'h2000, 8'h60, 8'h00, "R9 wrap");
    period(1, 0, 0, 0, 0, 8'h40, 8'h00, "R10 load over advance");
    for (int i = 0; i < 40; i++)
      period(i % 3 != 1, (i * 16'h1357) & 16'hFFFF, i % 3 == 1 && i % 2 == 0,
             0, 0, -1, -1, "mix");
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule